// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block gives a processor's simple memory bus control over a group of general-purpose pins. Each pin can be set to drive a level or to sense one. Two word-wide registers sit at a base address chosen by a parameter. One is the pin-data register and the other is the pin-direction register. A bus access is accepted only when the full address matches one of them, the master enable is high, and the read/not-write line has the value that the access needs.

Software reads and writes one data register, but the hardware splits it in two. Writes go to an output latch. Reads return a mix, chosen bit by bit by the direction register: the latched value for an output pin, and the live external level for an input pin. Tri-state pads do not synthesize well inside a core, so each pin has three separate signals instead: a driven value, an enable and a sensed value. A presence flag on each sensed pin stands in for a pull-up. External inputs pass through a synchronizer before any read can see them. Several copies of the block can share one bus if each has its own base address.

Top module: `gpio_port_mm`

## Requirements
- R1: After reset the direction register reads 0 (every pin is an input), the output latch holds 0, and `pin_oe` and `pin_out` are all 0.
- R2: The direction register is at BASE_ADDR+4. A write there takes effect on the clock edge of the access. `pin_oe[i]` then equals direction bit i, and a read at that address returns the value written.
- R3: The data register is at BASE_ADDR+0. A write there loads the output latch. For every pin whose direction bit is 1, `pin_out[i]` equals latch bit i.
- R4: A read at BASE_ADDR+0 returns, bit by bit, the latch bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0.
- R5: A change on `pin_in` at an input pin first shows in read data after the second rising clock edge. After one edge the read still returns the old level.
- R6: An input pin whose `pin_drv` flag is 0 has no external driver and reads as 1, whatever `pin_in` carries.
- R7: A register is accessed only when `bus_en` is 1 and `bus_addr` exactly equals its full address. `bus_rnw`=1 means read and 0 means write. In any other case `bus_rdata` is 0 and no register changes. A read never changes a register.
- R8: Writing a 1 to a data bit whose pin is an input leaves that pin undriven: `pin_oe[i]` and `pin_out[i]` stay 0, and a read still returns the external level.
- R9: A second instance with a base address 16 bytes higher responds only to its own two addresses. Accesses to either instance leave the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Master enable: qualifies every bus access |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W (32) | Full byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational, 0 when not selected |
| pin_in | input | PIN_W (32) | Sensed external level per pin |
| pin_drv | input | PIN_W (32) | 1 = an external source drives the pin; 0 = floating (reads 1) |
| pin_out | output | PIN_W (32) | Driven value per pin, 0 on input pins |
| pin_oe | output | PIN_W (32) | Output enable per pin (the direction bits) |

## Verification
A corrupted direction bit shows at `pin_oe` in the same cycle. It also changes which source a data read returns for that bit, so an input pin would echo the latch or an output pin would echo the external level. A wrong latch bit shows at `pin_out` as soon as its pin is an output. A fault in the input path shows only as timing: a synchronizer one stage too short or too long moves the first read of a new level by one clock. For that reason the bench reads the data register on each of the first edges after a pin toggles. Decode faults show up as a write that lands on the wrong register or on the other instance, or as nonzero read data on an unselected access.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Byte distance between the data register and the direction register.
   localparam int unsigned GPIO_REG_STRIDE = 4;

   // Qualified access strobes produced by the bus decoder.
   typedef struct packed {
      logic wr_dat;
      logic wr_dir;
      logic rd_dat;
      logic rd_dir;
   } gpio_sel_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_port_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   output gpio_sel_t         sel
);

   localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR;
   localparam logic [ADDR_W-1:0] DIR_ADDR = BASE_ADDR + ADDR_W'(GPIO_REG_STRIDE);

   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("gpio_bus_decode: ADDR_W must be at least 3");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("gpio_bus_decode: BASE_ADDR must be word aligned");
      end
   endgenerate

   logic hit_dat;
   logic hit_dir;

   // Full-width compare on every address bit.
   assign hit_dat = (bus_addr == DAT_ADDR);
   assign hit_dir = (bus_addr == DIR_ADDR);

   always_comb begin
      sel.wr_dat = bus_en & ~bus_rnw & hit_dat;
      sel.wr_dir = bus_en & ~bus_rnw & hit_dir;
      sel.rd_dat = bus_en &  bus_rnw & hit_dat;
      sel.rd_dir = bus_en &  bus_rnw & hit_dir;
   end

   // R7: at most one qualified strobe at a time
   p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R7: no strobe without the master enable
   p_strobe_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> (sel == '0));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam int unsigned CNT_W = $clog2(STAGES + 1);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

   // Cycles since reset, saturating; gates the latency check below.
   logic [CNT_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                          since_rst <= '0;
      else if (since_rst != CNT_W'(STAGES)) since_rst <= since_rst + 1'b1;
   end

   generate
      if (STAGES == 2) begin : g_lat_chk
         // R5: output equals input from exactly two edges earlier
         p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == CNT_W'(STAGES)) |-> (q == $past(d, 2)));
      end
   endgenerate

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
   import gpio_port_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gpio_sel_t         sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PIN_W-1:0]  pin_sync,
   output logic [PIN_W-1:0]  dir_q,
   output logic [PIN_W-1:0]  lat_q,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (PIN_W < 1 || PIN_W > DATA_W) begin : g_bad_pin_w
         $error("gpio_reg_bank: PIN_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [PIN_W-1:0] wr_val;
   logic [PIN_W-1:0] dat_view;
   logic [PIN_W-1:0] rd_pins;

   assign wr_val = wdata[PIN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         lat_q <= '0;
      end else begin
         if (sel.wr_dir) dir_q <= wr_val;
         if (sel.wr_dat) lat_q <= wr_val;
      end
   end

   // Per-bit source choice for a data read.
   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_view
         assign dat_view[i] = dir_q[i] ? lat_q[i] : pin_sync[i];
      end
   endgenerate

   always_comb begin
      if (sel.rd_dat)      rd_pins = dat_view;
      else if (sel.rd_dir) rd_pins = dir_q;
      else                 rd_pins = '0;
   end

   generate
      if (PIN_W == DATA_W) begin : g_full
         assign rdata = rd_pins;
      end else begin : g_pad
         assign rdata = {{(DATA_W-PIN_W){1'b0}}, rd_pins};
      end
   endgenerate

   // R2: direction write lands on the next edge
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel.wr_dir |=> (dir_q == $past(wr_val)));

   // R3: data write lands in the latch on the next edge
   p_lat_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel.wr_dat |=> (lat_q == $past(wr_val)));

   // R7: a read leaves both registers untouched
   p_read_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel.rd_dat || sel.rd_dir) |=> ($stable(dir_q) && $stable(lat_q)));

endmodule

// File: rtl/gpio_port_mm.sv
module gpio_port_mm
   import gpio_port_pkg::*;
#(
   parameter int unsigned       PIN_W       = 32,
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h4000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic [PIN_W-1:0]  pin_drv,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   gpio_sel_t        sel;
   logic [PIN_W-1:0] pin_level;
   logic [PIN_W-1:0] pin_sync;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] lat_q;

   gpio_bus_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_en   (bus_en),
      .bus_rnw  (bus_rnw),
      .bus_addr (bus_addr),
      .sel      (sel)
   );

   // Pin slices: pull-up model on the way in, gated drive on the way out.
   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
         assign pin_level[i] = pin_drv[i] ? pin_in[i] : 1'b1;
         assign pin_out[i]   = lat_q[i] & dir_q[i];
         assign pin_oe[i]    = dir_q[i];
      end
   endgenerate

   gpio_in_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_level),
      .q     (pin_sync)
   );

   gpio_reg_bank #(
      .PIN_W  (PIN_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync),
      .dir_q    (dir_q),
      .lat_q    (lat_q),
      .rdata    (bus_rdata)
   );

   // R7: no enabled write means no change at the pins
   p_idle_pins_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && !bus_rnw) |=> ($stable(pin_oe) && $stable(pin_out)));

   // R7: read data is zero without the master enable
   p_idle_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> (bus_rdata == '0));

   // R8: an input pin is never driven high
   p_input_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/gpio_port_mm_test.sv
module gpio_port_mm_test;

   localparam logic [31:0] BASE  = 32'h4000_1000;
   localparam logic [31:0] BASE2 = BASE + 32'd16;

   typedef struct {
      int          kind;   // 0 rdata uut, 1 pin_oe, 2 pin_out, 3 rdata uut2
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_rnw = 1'b1;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata, rdata2;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_drv = '1;
   logic [31:0] pin_out, pin_oe, pin_out2, pin_oe2;

   int checks = 0;
   int fails = 0;
   item_t q[$];
   logic [31:0] m_dir = '0, m_lat = '0, m_dir2 = '0, m_lat2 = '0;

   always #5 clk = ~clk;

   gpio_port_mm #(.BASE_ADDR(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
      .pin_in(pin_in), .pin_drv(pin_drv), .pin_out(pin_out), .pin_oe(pin_oe));

   gpio_port_mm #(.BASE_ADDR(BASE2)) uut2 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
      .pin_in(pin_in), .pin_drv(pin_drv), .pin_out(pin_out2), .pin_oe(pin_oe2));

   function automatic logic [31:0] lvl();
      return (pin_in & pin_drv) | ~pin_drv;
   endfunction

   function automatic logic [31:0] exp_rd(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] d, logic [31:0] l, logic en);
      if (!en)          return '0;
      if (a == b)       return (l & d) | (lvl() & ~d);
      if (a == b + 32'd4) return d;
      return '0;
   endfunction

   // Monitor: pops and compares everything queued for this cycle.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = rdata;
               1: act = pin_oe;
               2: act = pin_out;
               default: act = rdata2;
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   // All tasks are entered right after a falling edge.
   task automatic rd(logic [31:0] a, logic en, string tag);
      bus_en = en; bus_rnw = 1'b1; bus_addr = a;
      q.push_back('{0, exp_rd(a, BASE, m_dir, m_lat, en), tag});
      q.push_back('{3, exp_rd(a, BASE2, m_dir2, m_lat2, en), tag});
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic rd_exp(logic [31:0] e, string tag);
      bus_en = 1'b1; bus_rnw = 1'b1; bus_addr = BASE;
      q.push_back('{0, e, tag});
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic wr(logic [31:0] a, logic [31:0] d, logic en);
      bus_en = en; bus_rnw = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_rnw = 1'b1;
      if (en) begin
         if (a == BASE)          m_lat  = d;
         if (a == BASE + 32'd4)  m_dir  = d;
         if (a == BASE2)         m_lat2 = d;
         if (a == BASE2 + 32'd4) m_dir2 = d;
      end
   endtask

   task automatic chk_pins(string tag);
      q.push_back('{1, m_dir, tag});
      q.push_back('{2, m_lat & m_dir, tag});
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] old_v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1: reset state
      chk_pins("R1 reset pins");
      rd(BASE + 32'd4, 1'b1, "R1 dir after reset");
      wr(BASE + 32'd4, 32'hFFFF_FFFF, 1'b1);
      chk_pins("R1 latch cleared");
      @(negedge clk);

      // R2: direction register
      wr(BASE + 32'd4, 32'h0000_F0F0, 1'b1);
      chk_pins("R2 oe follows dir");
      rd(BASE + 32'd4, 1'b1, "R2 dir readback");

      // R6: floating pins read as one
      pin_drv = 32'hFFFF_FF00; pin_in = 32'h0;
      settle();
      rd(BASE, 1'b1, "R6 floating reads 1");

      // R3/R4: mixed output and input bits
      wr(BASE, 32'hA5A5_A5A5, 1'b1);
      chk_pins("R3 pin_out from latch");
      rd(BASE, 1'b1, "R4 mixed read");
      pin_in = 32'h1234_5600; settle();
      rd(BASE, 1'b1, "R4 mixed read pattern2");

      // R8: writes to input bits do not drive
      wr(BASE, 32'hFFFF_FFFF, 1'b1);
      chk_pins("R8 input pins undriven");
      rd(BASE, 1'b1, "R8 input bits show pin");

      // R5: two-edge latency on bit 16 (an input)
      old_v = exp_rd(BASE, BASE, m_dir, m_lat, 1'b1);
      pin_in[16] = ~pin_in[16];
      rd_exp(old_v, "R5 edge0 old");
      rd_exp(old_v, "R5 edge1 old");
      rd_exp(exp_rd(BASE, BASE, m_dir, m_lat, 1'b1), "R5 edge2 new");

      // R7: unqualified accesses
      wr(BASE + 32'd4, 32'h0000_000F, 1'b0);
      chk_pins("R7 write without enable");
      wr(BASE + 32'd8, 32'h0000_000F, 1'b1);
      chk_pins("R7 write to unmapped address");
      wr(BASE + 32'd5, 32'h0000_000F, 1'b1);
      chk_pins("R7 write to partial match");
      rd(BASE, 1'b0, "R7 read without enable");
      rd(BASE + 32'd8, 1'b1, "R7 read unmapped");
      rd(BASE + 32'd4, 1'b1, "R7 read keeps dir");

      // R9: second instance at base+16
      wr(BASE2 + 32'd4, 32'h0000_0001, 1'b1);
      wr(BASE2, 32'h0000_0003, 1'b1);
      chk_pins("R9 first instance untouched");
      rd(BASE2 + 32'd4, 1'b1, "R9 second dir");
      rd(BASE2, 1'b1, "R9 second data");
      rd(BASE + 32'd4, 1'b1, "R9 first dir kept");
      if (pin_oe2 !== 32'h1 || pin_out2 !== 32'h1) begin
         fails++;
         $display("FAIL R9 second pins actual=%h/%h expected=%h/%h", pin_oe2, pin_out2, 32'h1, 32'h1);
      end
      checks++;

      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule